// File: doc/BRIEF.md
# Nibble-Wide Stack Engine with Program-Counter Save

This block keeps a descending stack in a nibble-wide data memory, addressed by an 8-bit stack pointer that it owns. It accepts one request at a time: push a nibble, pop a nibble, save a 13-bit program counter, or restore one. The memory array itself sits outside the block. The block drives address, write data and strobes, and takes read data back in the same cycle.

A program-counter save stacks the counter's twelve low bits as three nibbles, the highest nibble first. A restore pops them back lowest nibble first. The top bit is the bank bit. It is never written to the stack. On a restore it takes the value presented with the restore request, so the bank in force at the time of the return is kept.

Requests use a valid/ready handshake. A request transfers on a cycle where both `req_valid` and `req_ready` are high. `req_ready` is low for the whole time an operation is running. While it is low, the requester must hold its request stable and wait; nothing is dropped. Completion is reported by a one-cycle `done` pulse, and a new request may transfer in that same cycle.

Top module: `nibble_stack`

## Requirements
- R1: Out of reset `busy`, `done`, `mem_we` and `mem_re` are low and `req_ready` is high; the stack pointer starts at SP_RESET (default 0).
- R2: A push (`req_op` = 0) performs one write cycle at address SP-1 carrying `req_nib`, and the stack pointer becomes SP-1.
- R3: A pop (`req_op` = 1) performs one read cycle at address SP, presents bits 3:0 of the read word on `pop_nib` (higher bits of `mem_rdata` are discarded), and the stack pointer becomes SP+1.
- R4: The stack pointer wraps modulo 256 in both directions: a push at SP=0 writes address 255, and a pop at SP=255 leaves SP at 0.
- R5: A save (`req_op` = 2) performs three consecutive write cycles at SP-1, SP-2 and SP-3, carrying `req_pc` bits 11:8, then 7:4, then 3:0; the stack pointer ends at SP-3.
- R6: A restore (`req_op` = 3) performs three consecutive read cycles at SP, SP+1 and SP+2, and fills `pc_out` bits 3:0, then 7:4, then 11:8 from them; the stack pointer ends at SP+3.
- R7: Bit 12 of `pc_out` after a restore equals bit 12 of `req_pc` given with the restore request, whatever bank was current when the value was saved.
- R8: A request transfers when `req_valid` and `req_ready` are both high. `busy` is high and `req_ready` low during every memory cycle of an operation. `done` pulses for exactly one cycle, in the cycle after the last memory cycle, with `busy` low and `req_ready` high; a request may transfer in that cycle.
- R9: `mem_we` and `mem_re` are never high together, and neither is high in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_op | input | 2 | 0 push, 1 pop, 2 save PC, 3 restore PC |
| req_nib | input | NIB_W | Nibble to push |
| req_pc | input | NIB_W*PC_NIBS+1 | PC to save; its top bit is the bank kept on restore |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pop_nib | output | NIB_W | Last popped nibble |
| pc_out | output | NIB_W*PC_NIBS+1 | Restored program counter |
| mem_addr | output | SP_W | Data memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | NIB_W | Memory write data |
| mem_rdata | input | MEM_W | Memory read data, valid in the cycle the address is driven |

## Verification
The bench builds the block with MEM_W = 8 and keeps the other defaults. The memory model holds random junk in the upper four bits of every word, so each pop and restore exercises the discarding of those bits. SP_RESET = 0 places the very first push on the downward wrap to address 255. Directed saves started at SP = 1 carry a three-nibble sequence across the 0/255 boundary.

// File: rtl/nstk_pkg.sv
package nstk_pkg;
  typedef enum logic [1:0] {
    OP_PUSH    = 2'd0,
    OP_POP     = 2'd1,
    OP_SAVE    = 2'd2,
    OP_RESTORE = 2'd3
  } nstk_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } nstk_state_e;
endpackage

// File: rtl/nstk_sp.sv
module nstk_sp #(
  parameter int             SP_W     = 8,
  parameter logic [SP_W-1:0] SP_RESET = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_dn,
  input  logic            step_up,
  output logic [SP_W-1:0] sp_q,
  output logic [SP_W-1:0] sp_dn
);
  localparam logic [SP_W-1:0] ONE = {{(SP_W-1){1'b0}}, 1'b1};

  // Decremented pointer: the address a write uses (pre-decrement)
  assign sp_dn = sp_q - ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sp_q <= SP_RESET;
    else if (step_dn) sp_q <= sp_dn;
    else if (step_up) sp_q <= sp_q + ONE;
  end
endmodule

// File: rtl/nstk_seq.sv
module nstk_seq
  import nstk_pkg::*;
#(
  parameter int STEP_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [STEP_W-1:0] last_in,
  output logic              busy,
  output logic [STEP_W-1:0] step,
  output logic              done
);
  localparam logic [STEP_W-1:0] STEP_ONE = {{(STEP_W-1){1'b0}}, 1'b1};

  nstk_state_e       state_q;
  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] last_q;
  logic              done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      last_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_RUN;
            step_q  <= '0;
            last_q  <= last_in;
          end
        end
        ST_RUN: begin
          if (step_q == last_q) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            step_q <= step_q + STEP_ONE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state_q == ST_RUN);
  assign step = step_q;
  assign done = done_q;
endmodule

// File: rtl/nstk_pcbuf.sv
module nstk_pcbuf #(
  parameter int NIB_W   = 4,
  parameter int PC_NIBS = 3,
  parameter int IDX_W   = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [NIB_W*PC_NIBS:0]     pc_in,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [NIB_W-1:0]           wr_nib,
  input  logic [IDX_W-1:0]           rd_idx,
  output logic [NIB_W-1:0]           rd_nib,
  output logic [NIB_W*PC_NIBS:0]     pc_q
);
  localparam int PC_W = NIB_W * PC_NIBS + 1;

  logic [NIB_W-1:0] nibs [PC_NIBS];
  logic             bank_q;

  // Bank bit: only ever taken from a request, never from memory
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bank_q <= 1'b0;
    else if (load) bank_q <= pc_in[PC_W-1];
  end

  for (genvar g = 0; g < PC_NIBS; g++) begin : g_nib
    logic [NIB_W-1:0] nib_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        nib_q <= '0;
      else if (load)
        nib_q <= pc_in[g*NIB_W +: NIB_W];
      else if (wr_en && (wr_idx == IDX_W'(g)))
        nib_q <= wr_nib;
    end
    assign nibs[g] = nib_q;
    assign pc_q[g*NIB_W +: NIB_W] = nib_q;
  end

  assign pc_q[PC_W-1] = bank_q;

  always_comb begin
    rd_nib = '0;
    for (int i = 0; i < PC_NIBS; i++) begin
      if (rd_idx == IDX_W'(i)) rd_nib = nibs[i];
    end
  end
endmodule

// File: rtl/nibble_stack.sv
module nibble_stack
  import nstk_pkg::*;
#(
  parameter int              NIB_W    = 4,
  parameter int              MEM_W    = 4,
  parameter int              SP_W     = 8,
  parameter int              PC_NIBS  = 3,
  parameter logic [SP_W-1:0] SP_RESET = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [1:0]               req_op,
  input  logic [NIB_W-1:0]         req_nib,
  input  logic [NIB_W*PC_NIBS:0]   req_pc,
  output logic                     busy,
  output logic                     done,
  output logic [NIB_W-1:0]         pop_nib,
  output logic [NIB_W*PC_NIBS:0]   pc_out,
  output logic [SP_W-1:0]          mem_addr,
  output logic                     mem_we,
  output logic                     mem_re,
  output logic [NIB_W-1:0]         mem_wdata,
  input  logic [MEM_W-1:0]         mem_rdata
);
  localparam int STEP_W = (PC_NIBS > 1) ? $clog2(PC_NIBS) : 1;
  localparam logic [STEP_W-1:0] LAST_PC = STEP_W'(PC_NIBS - 1);

  nstk_op_e          op_q;
  logic [NIB_W-1:0]  nib_q;
  logic              accept;
  logic              req_is_pc;
  logic              is_write;
  logic [STEP_W-1:0] step;
  logic [STEP_W-1:0] rd_idx;
  logic [NIB_W-1:0]  rd_nib;
  logic [NIB_W-1:0]  rd_low;
  logic [SP_W-1:0]   sp_q;
  logic [SP_W-1:0]   sp_dn;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign req_is_pc = (req_op == OP_SAVE) || (req_op == OP_RESTORE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_PUSH;
      nib_q <= '0;
    end else if (accept) begin
      op_q  <= nstk_op_e'(req_op);
      nib_q <= req_nib;
    end
  end

  nstk_seq #(.STEP_W(STEP_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .last_in (req_is_pc ? LAST_PC : '0),
    .busy    (busy),
    .step    (step),
    .done    (done)
  );

  // Writes (push, save) pre-decrement; reads (pop, restore) post-increment
  assign is_write = (op_q == OP_PUSH) || (op_q == OP_SAVE);
  assign mem_we   = busy && is_write;
  assign mem_re   = busy && !is_write;

  nstk_sp #(.SP_W(SP_W), .SP_RESET(SP_RESET)) u_sp (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_dn (mem_we),
    .step_up (mem_re),
    .sp_q    (sp_q),
    .sp_dn   (sp_dn)
  );

  assign mem_addr = is_write ? sp_dn : sp_q;
  assign rd_low   = mem_rdata[NIB_W-1:0];

  // Save walks nibbles high to low; restore fills low to high
  assign rd_idx = LAST_PC - step;

  nstk_pcbuf #(.NIB_W(NIB_W), .PC_NIBS(PC_NIBS), .IDX_W(STEP_W)) u_pc (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept && req_is_pc),
    .pc_in  (req_pc),
    .wr_en  (mem_re && (op_q == OP_RESTORE)),
    .wr_idx (step),
    .wr_nib (rd_low),
    .rd_idx (rd_idx),
    .rd_nib (rd_nib),
    .pc_q   (pc_out)
  );

  assign mem_wdata = (op_q == OP_PUSH) ? nib_q : rd_nib;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          pop_nib <= '0;
    else if (mem_re && (op_q == OP_POP)) pop_nib <= rd_low;
  end
endmodule

// File: rtl/nibble_stack_chk.sv
module nibble_stack_chk #(
  parameter int SP_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            busy,
  input logic            done,
  input logic            mem_we,
  input logic            mem_re,
  input logic [SP_W-1:0] mem_addr
);
  // R9
  mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(mem_we || mem_re));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && req_ready));

  // R5
  save_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == SP_W'($past(mem_addr) - 1'b1)));

  // R6
  rest_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && $past(mem_re)) |-> (mem_addr == SP_W'($past(mem_addr) + 1'b1)));
endmodule

bind nibble_stack nibble_stack_chk #(.SP_W(SP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .busy      (busy),
  .done      (done),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .mem_addr  (mem_addr)
);

// File: tb/nibble_stack_test.sv
`timescale 1ns/1ps
module nibble_stack_test;
  localparam int NIB_W = 4;
  localparam int MEM_W = 8;
  localparam int SP_W  = 8;
  localparam int PC_W  = 13;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [1:0]       req_op = '0;
  logic [NIB_W-1:0] req_nib = '0;
  logic [PC_W-1:0]  req_pc = '0;
  logic             busy, done;
  logic [NIB_W-1:0] pop_nib;
  logic [PC_W-1:0]  pc_out;
  logic [SP_W-1:0]  mem_addr;
  logic             mem_we, mem_re;
  logic [NIB_W-1:0] mem_wdata;
  logic [MEM_W-1:0] mem_rdata;

  logic [MEM_W-1:0] mem [256];

  int n_tests = 0;
  int n_fail  = 0;
  logic [SP_W-1:0] exp_sp = '0;
  logic [PC_W-1:0] exp_pc;
  logic [NIB_W-1:0] exp_pop;

  always #2 clk = ~clk;

  nibble_stack #(.MEM_W(MEM_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_nib(req_nib), .req_pc(req_pc), .busy(busy),
    .done(done), .pop_nib(pop_nib), .pc_out(pc_out), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  // Memory model: combinational read, write keeps the junk upper bits
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= {mem[mem_addr][MEM_W-1:NIB_W], mem_wdata};
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NIB_W-1:0] pc_nib(input logic [PC_W-1:0] pc, input int k);
    return pc[k*NIB_W +: NIB_W];
  endfunction

  // op: 0 push, 1 pop, 2 save, 3 restore. b2b: offer in the done cycle.
  task automatic run_op(input logic [1:0] op, input logic [3:0] nib,
                        input logic [PC_W-1:0] pc, input bit b2b);
    int steps;
    logic [SP_W-1:0] a;
    steps = (op >= 2'd2) ? 3 : 1;
    if (!b2b) @(negedge clk);
    chk("R8 ready before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_op = op; req_nib = nib; req_pc = pc;
    @(negedge clk);
    req_valid = 1'b0;
    req_op = 2'($urandom); req_nib = 4'($urandom); req_pc = 13'($urandom);
    for (int k = 0; k < steps; k++) begin
      if (k > 0) @(negedge clk);
      chk("R8 busy in memory cycle", {31'd0, busy}, 32'd1);
      chk("R8 ready low in memory cycle", {31'd0, req_ready}, 32'd0);
      case (op)
        2'd0: begin
          a = exp_sp - 8'd1;
          chk("R2 push strobes", {30'd0, mem_we, mem_re}, 32'd2);
          chk("R2 push addr", {24'd0, mem_addr}, {24'd0, a});
          chk("R2 push data", {28'd0, mem_wdata}, {28'd0, nib});
          exp_sp = a;
        end
        2'd1: begin
          chk("R3 pop strobes", {30'd0, mem_we, mem_re}, 32'd1);
          chk("R3 pop addr", {24'd0, mem_addr}, {24'd0, exp_sp});
          exp_pop = mem[exp_sp][NIB_W-1:0];
          exp_sp = exp_sp + 8'd1;
        end
        2'd2: begin
          a = exp_sp - 8'd1;
          chk("R5 save strobes", {30'd0, mem_we, mem_re}, 32'd2);
          chk("R5 save addr", {24'd0, mem_addr}, {24'd0, a});
          chk("R5 save data", {28'd0, mem_wdata}, {28'd0, pc_nib(pc, 2 - k)});
          exp_sp = a;
        end
        default: begin
          chk("R6 restore strobes", {30'd0, mem_we, mem_re}, 32'd1);
          chk("R6 restore addr", {24'd0, mem_addr}, {24'd0, exp_sp});
          exp_pc[k*NIB_W +: NIB_W] = mem[exp_sp][NIB_W-1:0];
          exp_sp = exp_sp + 8'd1;
        end
      endcase
    end
    @(negedge clk);
    chk("R8 done pulse", {31'd0, done}, 32'd1);
    chk("R8 not busy at done", {31'd0, busy}, 32'd0);
    chk("R9 no strobe at done", {30'd0, mem_we, mem_re}, 32'd0);
    if (op == 2'd1) chk("R3 pop value", {28'd0, pop_nib}, {28'd0, exp_pop});
    if (op == 2'd3) begin
      exp_pc[PC_W-1] = pc[PC_W-1];
      chk("R6 R7 restored pc", {19'd0, pc_out}, {19'd0, exp_pc});
    end
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd1789;
    void'($urandom(seed));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);

    repeat (3) @(negedge clk);
    chk("R1 busy in reset", {31'd0, busy}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 ready", {31'd0, req_ready}, 32'd1);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 strobes", {30'd0, mem_we, mem_re}, 32'd0);

    // R4: first push wraps down to 255, pop wraps back up to 0
    run_op(2'd0, 4'hA, '0, 1'b0);
    chk("R4 push wrote 255", {28'd0, mem[255][3:0]}, 32'hA);
    run_op(2'd1, 4'h0, '0, 1'b1);
    chk("R4 pop of wrapped push", {28'd0, pop_nib}, 32'hA);
    // R3: pop at 0 returns only the low nibble of a junk-filled word
    mem[0] = 8'hB6;
    run_op(2'd1, 4'h0, '0, 1'b0);
    chk("R3 mask", {28'd0, pop_nib}, 32'h6);
    // R5: save at SP=1 crosses the 0/255 boundary
    run_op(2'd2, 4'h0, 13'h1ABC, 1'b0);
    chk("R5 high nibble at 0", {28'd0, mem[0][3:0]}, 32'hA);
    chk("R5 mid nibble at 255", {28'd0, mem[255][3:0]}, 32'hB);
    chk("R5 low nibble at 254", {28'd0, mem[254][3:0]}, 32'hC);
    // R7: restore with bank 0 after saving with bank 1
    run_op(2'd3, 4'h0, 13'h0555, 1'b1);
    chk("R7 bank from request", {19'd0, pc_out}, 32'h0ABC);
    chk("R4 sp back to 1", {24'd0, exp_sp}, 32'd1);
    run_op(2'd2, 4'h0, 13'h0123, 1'b0);
    run_op(2'd3, 4'h0, 13'h1FFF, 1'b0);
    chk("R7 bank set on restore", {19'd0, pc_out}, 32'h1123);

    // Random mix of all four operations
    for (int n = 0; n < 400; n++) begin
      run_op(2'($urandom), 4'($urandom), 13'($urandom), bit'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule